// File: doc/BRIEF.md
# Codec Control Register Bank Behind Command Slots

This block is the control register file on the codec side of a time-slotted audio link. Each frame carries two 20-bit control slots. The block receives them together, under a one-cycle frame strobe. The first slot holds an operation flag and a 7-bit register index. The second slot holds write data in its upper 16 bits. A write updates one of 128 16-bit registers. A read returns the register's contents one cycle later, in the shape of two return slots.

Every location has a reset default, and most defaults are zero. Three identification locations are write-protected. A write to index 0 is a soft reset: every location goes back to its default. A write to the DAC sample-rate location also raises a one-cycle event that carries the new rate, so the audio path can change its conversion rate.

Top module: `codec_ctrl_regs`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `rsp_valid_o` and `rate_evt_o` are low and every location holds its default.
- R2: A frame with `cmd_slot_i[19]`=0 is a write. It stores `data_slot_i[19:4]` at index `cmd_slot_i[18:12]`. Later reads of that index return the stored value.
- R3: A frame with `cmd_slot_i[19]`=1 is a read. In the next cycle `rsp_valid_o` is high, `rsp_slot1_o` equals `cmd_slot_i` with bit 19 cleared, and `rsp_slot2_o` equals the register value shifted left by 4, so bits 3:0 are zero. The value returned is the one held before that frame.
- R4: Writes to indices 0x28, 0x7C and 0x7E leave those locations unchanged.
- R5: A write to index 0x00, whatever its data, returns every location to its default.
- R6: The defaults are: 0x00=0x0D50, 0x02=0x8008, 0x04=0x8000, 0x06=0x8000, 0x0C=0x8008, 0x0E=0x8008, 0x10/0x12/0x14/0x16/0x18=0x8808, 0x1C=0x8000, 0x22=0x0101, 0x28=0x0001, 0x2C=0xBB80, 0x32=0xBB80, 0x7C=0x5A31 and 0x7E=0x0004 (the last two are parameters). All other locations default to zero.
- R7: A write to index 0x2C pulses `rate_evt_o` in the next cycle, with `rate_val_o` equal to the written data. When no event is signalled, `rate_val_o` is zero.
- R8: A cycle with `frame_stb_i` low changes no location and produces neither a response nor a rate event, whatever the slot inputs hold.
- R9: When `rsp_valid_o` is low, `rsp_slot1_o` and `rsp_slot2_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb_i | input | 1 | Both control slots are present this cycle |
| cmd_slot_i | input | 20 | Operation flag and register index |
| data_slot_i | input | 20 | Write data in bits 19:4 |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_slot1_o | output | 20 | Echoed command slot with the operation flag cleared |
| rsp_slot2_o | output | 20 | Register value in bits 19:4 |
| rate_evt_o | output | 1 | DAC rate was written in the previous cycle |
| rate_val_o | output | 16 | New DAC rate during the event |

## Verification
The bench scans all 128 locations after reset and after a soft reset. A wrong or shifted default would show up as a mismatched read, and a soft reset that only cleared index 0 would leave stale patterns behind. It writes to the protected indices and then reads them back, which catches a bank that lets a write through. It drives write commands with the strobe low, which exposes a decoder that ignores the strobe. It also issues back-to-back rate writes and reads whose low command bits are non-zero. A response that dropped those bits or left the flag set would fail, and so would an event that was late or carried the old rate.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;

    localparam logic [6:0] IDX_SOFT_RESET = 7'h00;
    localparam logic [6:0] IDX_EXT_ID     = 7'h28;
    localparam logic [6:0] IDX_DAC_RATE   = 7'h2C;
    localparam logic [6:0] IDX_VID_HI     = 7'h7C;
    localparam logic [6:0] IDX_VID_LO     = 7'h7E;

    // Power-on contents of one location.
    function automatic logic [15:0] reg_default(input logic [6:0] idx,
                                                input logic [15:0] vid_hi,
                                                input logic [15:0] vid_lo);
        logic [15:0] v;
        case (idx)
            7'h00:                          v = 16'h0D50;
            7'h02, 7'h0C, 7'h0E:            v = 16'h8008;
            7'h04, 7'h06, 7'h1C:            v = 16'h8000;
            7'h10, 7'h12, 7'h14,
            7'h16, 7'h18:                   v = 16'h8808;
            7'h22:                          v = 16'h0101;
            IDX_EXT_ID:                     v = 16'h0001;
            IDX_DAC_RATE, 7'h32:            v = 16'hBB80;
            IDX_VID_HI:                     v = vid_hi;
            IDX_VID_LO:                     v = vid_lo;
            default:                        v = 16'h0000;
        endcase
        return v;
    endfunction

    function automatic logic reg_read_only(input logic [6:0] idx);
        return (idx == IDX_EXT_ID) || (idx == IDX_VID_HI) || (idx == IDX_VID_LO);
    endfunction

endpackage

// File: rtl/slot_cmd_decode.sv
module slot_cmd_decode #(
    parameter int SLOT_W = 20,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              frame_stb,
    input  logic [SLOT_W-1:0] slot1,
    input  logic [SLOT_W-1:0] slot2,
    output logic              wr_en,
    output logic              rd_en,
    output logic [ADDR_W-1:0] idx,
    output logic [DATA_W-1:0] wdata,
    output logic              rate_hit
);
    import codec_reg_pkg::*;

    localparam int RW_BIT   = SLOT_W - 1;
    localparam int ADDR_LSB = RW_BIT - ADDR_W;
    localparam int DATA_LSB = SLOT_W - DATA_W;

    always_comb begin
        idx      = slot1[RW_BIT-1 -: ADDR_W];
        wdata    = slot2[SLOT_W-1 -: DATA_W];
        wr_en    = frame_stb && !slot1[RW_BIT];
        rd_en    = frame_stb &&  slot1[RW_BIT];
        rate_hit = wr_en && (idx == ADDR_W'(IDX_DAC_RATE));
    end

    logic unused_low_bits;
    assign unused_low_bits = ^{slot1[ADDR_LSB-1:0], slot2[DATA_LSB-1:0]};

endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank #(
    parameter int          ADDR_W = 7,
    parameter int          DATA_W = 16,
    parameter logic [15:0] VID_HI = 16'h5A31,
    parameter logic [15:0] VID_LO = 16'h0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_value
);
    import codec_reg_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] dflt    [DEPTH];
    logic [DEPTH-1:0]  ro_mask;
    logic [DATA_W-1:0] bank_d  [DEPTH];
    logic [DATA_W-1:0] bank_q  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_loc
        assign dflt[g]    = DATA_W'(reg_default(7'(g), VID_HI, VID_LO));
        assign ro_mask[g] = reg_read_only(7'(g));
    end

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            if (wr_idx == ADDR_W'(IDX_SOFT_RESET)) begin
                for (int i = 0; i < DEPTH; i++) begin
                    bank_d[i] = dflt[i];
                end
            end else if (!ro_mask[wr_idx]) begin
                bank_d[wr_idx] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                bank_q[i] <= dflt[i];
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_value = bank_q[rd_idx];

endmodule

// File: rtl/slot_rsp_gen.sv
module slot_rsp_gen #(
    parameter int SLOT_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [SLOT_W-1:0] req_slot1,
    input  logic [DATA_W-1:0] rd_value,
    input  logic              rate_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic              rsp_valid,
    output logic [SLOT_W-1:0] rsp_slot1,
    output logic [SLOT_W-1:0] rsp_slot2,
    output logic              rate_evt,
    output logic [DATA_W-1:0] rate_val
);
    localparam int RW_BIT   = SLOT_W - 1;
    localparam int DATA_LSB = SLOT_W - DATA_W;

    typedef struct packed {
        logic              vld;
        logic [SLOT_W-1:0] s1;
        logic [SLOT_W-1:0] s2;
        logic              evt;
        logic [DATA_W-1:0] rate;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (rd_en) begin
            st_d.vld = 1'b1;
            st_d.s1  = req_slot1 & ~(SLOT_W'(1) << RW_BIT);
            st_d.s2  = {rd_value, {DATA_LSB{1'b0}}};
        end
        if (rate_hit) begin
            st_d.evt  = 1'b1;
            st_d.rate = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.vld;
    assign rsp_slot1 = st_q.s1;
    assign rsp_slot2 = st_q.s2;
    assign rate_evt  = st_q.evt;
    assign rate_val  = st_q.rate;

endmodule

// File: rtl/codec_ctrl_regs.sv
module codec_ctrl_regs #(
    parameter int          SLOT_W = 20,
    parameter int          ADDR_W = 7,
    parameter int          DATA_W = 16,
    parameter logic [15:0] VID_HI = 16'h5A31,
    parameter logic [15:0] VID_LO = 16'h0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb_i,
    input  logic [SLOT_W-1:0] cmd_slot_i,
    input  logic [SLOT_W-1:0] data_slot_i,
    output logic              rsp_valid_o,
    output logic [SLOT_W-1:0] rsp_slot1_o,
    output logic [SLOT_W-1:0] rsp_slot2_o,
    output logic              rate_evt_o,
    output logic [DATA_W-1:0] rate_val_o
);
    logic              wr_en, rd_en, rate_hit;
    logic [ADDR_W-1:0] idx;
    logic [DATA_W-1:0] wdata, rd_value;

    slot_cmd_decode #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .frame_stb (frame_stb_i),
        .slot1     (cmd_slot_i),
        .slot2     (data_slot_i),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .idx       (idx),
        .wdata     (wdata),
        .rate_hit  (rate_hit)
    );

    ctrl_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VID_HI(VID_HI), .VID_LO(VID_LO)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (idx),
        .wr_data  (wdata),
        .rd_idx   (idx),
        .rd_value (rd_value)
    );

    slot_rsp_gen #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .req_slot1 (cmd_slot_i),
        .rd_value  (rd_value),
        .rate_hit  (rate_hit),
        .wdata     (wdata),
        .rsp_valid (rsp_valid_o),
        .rsp_slot1 (rsp_slot1_o),
        .rsp_slot2 (rsp_slot2_o),
        .rate_evt  (rate_evt_o),
        .rate_val  (rate_val_o)
    );

endmodule

// File: rtl/codec_regs_chk.sv
module codec_regs_chk #(
    parameter int SLOT_W = 20,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_stb_i,
    input logic [SLOT_W-1:0] cmd_slot_i,
    input logic [SLOT_W-1:0] data_slot_i,
    input logic              rsp_valid_o,
    input logic [SLOT_W-1:0] rsp_slot1_o,
    input logic [SLOT_W-1:0] rsp_slot2_o,
    input logic              rate_evt_o,
    input logic [DATA_W-1:0] rate_val_o
);
    localparam int RW_BIT = SLOT_W - 1;
    localparam logic [ADDR_W-1:0] RATE_IDX = ADDR_W'(7'h2C);

    logic is_rd, is_rate_wr;
    assign is_rd      = frame_stb_i && cmd_slot_i[RW_BIT];
    assign is_rate_wr = frame_stb_i && !cmd_slot_i[RW_BIT]
                        && (cmd_slot_i[RW_BIT-1 -: ADDR_W] == RATE_IDX);

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> rsp_valid_o); // R3
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> !rsp_valid_o); // R8
    AST_ECHO_SLOT1: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> (rsp_slot1_o == ($past(cmd_slot_i) & ~(SLOT_W'(1) << RW_BIT)))); // R3
    AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (rsp_slot2_o[3:0] == 4'h0)); // R3
    AST_IDLE_SLOTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid_o |-> (rsp_slot1_o == '0 && rsp_slot2_o == '0)); // R9
    AST_RATE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        is_rate_wr |=> rate_evt_o); // R7
    AST_RATE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rate_wr |=> !rate_evt_o); // R7
    AST_RATE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        is_rate_wr |=> (rate_val_o == $past(data_slot_i[SLOT_W-1 -: DATA_W]))); // R7
    AST_RATE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_evt_o |-> (rate_val_o == '0)); // R7

endmodule

bind codec_ctrl_regs codec_regs_chk #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_stb_i (frame_stb_i),
    .cmd_slot_i  (cmd_slot_i),
    .data_slot_i (data_slot_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_slot1_o (rsp_slot1_o),
    .rsp_slot2_o (rsp_slot2_o),
    .rate_evt_o  (rate_evt_o),
    .rate_val_o  (rate_val_o)
);

// File: tb/sim_codec_ctrl_regs.sv
`timescale 1ns/1ps
module sim_codec_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb_i = 1'b0;
    logic [19:0] cmd_slot_i = '0;
    logic [19:0] data_slot_i = '0;
    logic        rsp_valid_o;
    logic [19:0] rsp_slot1_o;
    logic [19:0] rsp_slot2_o;
    logic        rate_evt_o;
    logic [15:0] rate_val_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [15:0] mdl [128];

    always #2.5 clk = ~clk;

    codec_ctrl_regs u0 (
        .clk(clk), .rst_n(rst_n), .frame_stb_i(frame_stb_i),
        .cmd_slot_i(cmd_slot_i), .data_slot_i(data_slot_i),
        .rsp_valid_o(rsp_valid_o), .rsp_slot1_o(rsp_slot1_o), .rsp_slot2_o(rsp_slot2_o),
        .rate_evt_o(rate_evt_o), .rate_val_o(rate_val_o)
    );

    // Default contents as listed in R6.
    function automatic logic [15:0] expect_default(input int a);
        if (a == 0) return 16'h0D50;
        if (a == 2 || a == 12 || a == 14) return 16'h8008;
        if (a == 4 || a == 6 || a == 28) return 16'h8000;
        if (a >= 16 && a <= 24 && a % 2 == 0) return 16'h8808;
        if (a == 34) return 16'h0101;
        if (a == 40) return 16'h0001;
        if (a == 44 || a == 50) return 16'hBB80;
        if (a == 124) return 16'h5A31;
        if (a == 126) return 16'h0004;
        return 16'h0000;
    endfunction

    function automatic bit protected_loc(input int a);
        return a == 40 || a == 124 || a == 126;
    endfunction

    task automatic load_defaults();
        for (int a = 0; a < 128; a++) mdl[a] = expect_default(a);
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at a falling edge, compare after the next rising edge.
    task automatic step(input bit stb, input bit rd, input int idx, input logic [11:0] low,
                        input logic [15:0] val, input logic [3:0] dlow, input string tag);
        logic [19:0] c, d;
        bit          e_vld, e_evt;
        logic [19:0] e_s1, e_s2;
        logic [15:0] e_rate;
        c = {rd, idx[6:0], low};
        d = {val, dlow};
        e_vld  = stb && rd;
        e_s1   = e_vld ? {1'b0, idx[6:0], low} : 20'h0;
        e_s2   = e_vld ? {mdl[idx], 4'h0} : 20'h0;
        e_evt  = stb && !rd && idx == 44;
        e_rate = e_evt ? val : 16'h0;
        if (stb && !rd) begin
            if (idx == 0) load_defaults();
            else if (!protected_loc(idx)) mdl[idx] = val;
        end
        frame_stb_i = stb;
        cmd_slot_i  = c;
        data_slot_i = d;
        @(negedge clk);
        chk(tag, "rsp_valid", 32'(rsp_valid_o), 32'(e_vld));
        chk(tag, "rsp_slot1", 32'(rsp_slot1_o), 32'(e_s1));
        chk(tag, "rsp_slot2", 32'(rsp_slot2_o), 32'(e_s2));
        chk(tag, "rate_evt", 32'(rate_evt_o), 32'(e_evt));
        chk(tag, "rate_val", 32'(rate_val_o), 32'(e_rate));
        frame_stb_i = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [15:0] v, input string tag);
        step(1'b1, 1'b0, idx, 12'h000, v, 4'h0, tag);
    endtask

    task automatic rd(input int idx, input string tag);
        step(1'b1, 1'b1, idx, 12'h000, 16'h0, 4'h0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        load_defaults();
        repeat (3) @(negedge clk);
        // R1: outputs quiet while reset is held
        chk("R1", "rsp_valid in reset", 32'(rsp_valid_o), 32'h0);
        chk("R1", "rate_evt in reset", 32'(rate_evt_o), 32'h0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 0, 12'h0, 16'h0, 4'h0, "R1");
        rd(0, "R1");
        rd(44, "R1");

        // R6: full default scan
        for (int a = 0; a < 128; a++) rd(a, "R6");

        // R2: write a pattern to every non-zero index, then read back
        for (int a = 1; a < 128; a++) wr(a, 16'(a * 16'h0133) ^ 16'hA5A5, "R2");
        for (int a = 0; a < 128; a++) rd(a, "R2");

        // R4: protected locations keep their values
        wr(40, 16'hFFFF, "R4");
        wr(124, 16'h1111, "R4");
        wr(126, 16'h2222, "R4");
        rd(40, "R4");
        rd(124, "R4");
        rd(126, "R4");

        // R7: rate events, back to back, then a read of the rate
        wr(44, 16'hAC44, "R7");
        wr(44, 16'h5622, "R7");
        step(1'b0, 1'b0, 0, 12'h0, 16'h0, 4'h0, "R7");
        rd(44, "R7");
        wr(45, 16'h1F40, "R7");

        // R8: no strobe, write-shaped slots
        step(1'b0, 1'b0, 2, 12'h000, 16'hDEAD, 4'h0, "R8");
        step(1'b0, 1'b0, 44, 12'h000, 16'hBEEF, 4'h0, "R8");
        step(1'b0, 1'b1, 3, 12'hFFF, 16'h0, 4'h0, "R8");
        step(1'b0, 1'b0, 0, 12'h000, 16'h0, 4'h0, "R8");
        rd(2, "R8");
        rd(44, "R8");
        rd(5, "R8");

        // R3: reads with non-zero low command bits and dirty data slots
        step(1'b1, 1'b1, 16, 12'hABC, 16'h1234, 4'hF, "R3");
        step(1'b1, 1'b1, 17, 12'hFFF, 16'h0, 4'h9, "R3");
        step(1'b1, 1'b0, 17, 12'h5A5, 16'h7777, 4'hF, "R3");
        step(1'b1, 1'b1, 17, 12'h001, 16'h0, 4'h0, "R3");

        // R9: idle cycles show zero slots
        step(1'b0, 1'b1, 7, 12'h123, 16'hFFFF, 4'hF, "R9");
        step(1'b0, 1'b0, 0, 12'h0, 16'h0, 4'h0, "R9");

        // R5: soft reset through index 0, then full scan
        wr(0, 16'h1234, "R5");
        for (int a = 0; a < 128; a++) rd(a, "R5");
        wr(3, 16'h4321, "R5");
        step(1'b1, 1'b0, 0, 12'hFFF, 16'h0000, 4'hF, "R5");
        rd(3, "R5");
        rd(0, "R5");

        finish_run();
    end

endmodule